// File: doc/BRIEF.md
# Receive FIFO with Per-Byte Error Tags

This block buffers the bytes that a serial frame receiver produces. It sits between the receive logic and the data and status registers that software or a DMA engine reads. Each stored byte carries three hidden tag bits. One marks the last byte of a frame, one marks a failed CRC check on that frame, and one marks the last byte accepted before an overrun. Software cannot read the tags directly. They travel down the queue with their byte. When the byte reaches the bottom of the queue, its CRC and overrun tags appear on the status flags.

While any occupied entry among the lowest eight holds a tag, the block raises a frame-attention flag and an interrupt. It also withholds the DMA request, so that a DMA engine never drains past a frame boundary or an error. Software must therefore sample the status flags before it reads the data byte, because each read advances the queue and replaces the flags.

Top module: `rx_tag_fifo`

## Requirements
- R1: The queue holds 16 entries in first-in first-out order. `rd_data` shows the oldest byte, and a pulse on `rd_en` removes that byte so the next one appears.
- R2: A byte written with `wr_crc_bad` high shows `st_crc_err` = 1 while it is the bottom byte, and only then.
- R3: A write while the queue holds 16 entries, with no read in that cycle, drops the incoming byte and sets the overrun tag on the newest stored byte.
- R4: `st_crc_err` and `st_ovr` describe the bottom byte alone, and both read 0 when the queue is empty.
- R5: `attn` is 1 exactly when one of the lowest eight occupied entries carries any of the three tags (end of frame, CRC, overrun). `irq` equals `attn`.
- R6: `dma_req` is 1 exactly when at least 8 entries are occupied and `attn` is 0.
- R7: A write and a read in the same cycle on a full queue are both accepted, and no overrun tag is set.
- R8: A read of an empty queue leaves `rd_data` at the last byte removed and changes no flag.
- R9: A synchronous reset empties the queue, clears every tag, drives `rd_data` to 0, and clears `st_crc_err`, `st_ovr`, `attn`, `irq` and `dma_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte valid from the receive logic |
| wr_data | input | 8 | Received byte |
| wr_eof | input | 1 | The byte is the last byte of its frame |
| wr_crc_bad | input | 1 | The frame ending with this byte failed its CRC |
| rd_en | input | 1 | Read strobe on the data register |
| rd_data | output | 8 | Bottom byte, or the last byte removed when empty |
| st_crc_err | output | 1 | CRC tag of the bottom byte |
| st_ovr | output | 1 | Overrun tag of the bottom byte |
| attn | output | 1 | A tagged entry lies in the lowest eight |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | Receive DMA request |

## Verification
The bench overruns a full queue. The newest byte sits beyond the watched window, so `attn` must stay low until exactly eight reads bring the tag into view. A design with an off-by-one window, or one that tags the wrong entry, shifts that cycle or shows the overrun flag on the wrong byte. A simultaneous read and write on a full queue checks that no false overrun appears and that nothing is lost. A design that blocks the write would miss the last byte. Reads of an empty queue check that the data register holds its last byte and that the pointers do not move. A design that advances on empty would return stale entries later. A CRC-tagged byte and an end-of-frame-only byte check that the flags follow the bottom byte and that `dma_req` falls when a tag is in view.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int BYTE_W = 8;

    // Bit 10 overrun, bit 9 CRC failure, bit 8 end of frame.
    typedef struct packed {
        logic              ovr;
        logic              crc;
        logic              eof;
        logic [BYTE_W-1:0] data;
    } rxq_entry_t;

    typedef logic [2:0] rxq_tags_t;

    function automatic rxq_tags_t tags_of(rxq_entry_t e);
        return {e.ovr, e.crc, e.eof};
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  rxq_entry_t             wr_ent,
    input  logic                   rd_en,
    output rxq_entry_t             bottom_o,
    output rxq_tags_t [DEPTH-1:0]  tags_o,
    output logic [PTR_W-1:0]       rd_ptr_o,
    output logic [CNT_W-1:0]       cnt_o,
    output logic [BYTE_W-1:0]      last_o
);

    rxq_entry_t        mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] last_q;

    logic full, empty, pop, push, ovr_hit;

    always_comb begin
        full    = (cnt == CNT_W'(DEPTH));
        empty   = (cnt == '0);
        pop     = rd_en && !empty;
        push    = wr_en && (!full || pop);
        ovr_hit = wr_en && full && !pop;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
            last_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else begin
            if (push) begin
                mem[wr_ptr] <= wr_ent;
                wr_ptr      <= wr_ptr + PTR_W'(1);
            end
            if (ovr_hit) begin
                mem[wr_ptr - PTR_W'(1)].ovr <= 1'b1;
            end
            if (pop) begin
                last_q <= mem[rd_ptr].data;
                rd_ptr <= rd_ptr + PTR_W'(1);
            end
            if (push && !pop) begin
                cnt <= cnt + CNT_W'(1);
            end else if (pop && !push) begin
                cnt <= cnt - CNT_W'(1);
            end
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_tags
            assign tags_o[g] = tags_of(mem[g]);
        end
    endgenerate

    assign bottom_o = mem[rd_ptr];
    assign rd_ptr_o = rd_ptr;
    assign cnt_o    = cnt;
    assign last_o   = last_q;

endmodule

// File: rtl/rxq_scan.sv
module rxq_scan
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int WATCH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  rxq_tags_t [DEPTH-1:0] tags_i,
    input  logic [PTR_W-1:0]      rd_ptr,
    input  logic [CNT_W-1:0]      cnt,
    output logic                  hit_o
);

    logic [WATCH-1:0] hits;

    generate
        for (genvar g = 0; g < WATCH; g++) begin : g_win
            logic [PTR_W-1:0] idx;
            assign idx     = rd_ptr + PTR_W'(g);
            assign hits[g] = (CNT_W'(g) < cnt) && (|tags_i[idx]);
        end
    endgenerate

    assign hit_o = |hits;

endmodule

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int WATCH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic              wr_eof,
    input  logic              wr_crc_bad,
    input  logic              rd_en,
    output logic [7:0]        rd_data,
    output logic              st_crc_err,
    output logic              st_ovr,
    output logic              attn,
    output logic              irq,
    output logic              dma_req
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    rxq_entry_t            wr_ent;
    rxq_entry_t            bottom;
    rxq_tags_t [DEPTH-1:0] tags;
    logic [PTR_W-1:0]      rd_ptr;
    logic [CNT_W-1:0]      cnt;
    logic [BYTE_W-1:0]     last_byte;
    logic                  have_data;
    logic                  window_hit;

    always_comb begin
        wr_ent      = '0;
        wr_ent.data = wr_data;
        wr_ent.eof  = wr_eof;
        wr_ent.crc  = wr_crc_bad;
    end

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_ent   (wr_ent),
        .rd_en    (rd_en),
        .bottom_o (bottom),
        .tags_o   (tags),
        .rd_ptr_o (rd_ptr),
        .cnt_o    (cnt),
        .last_o   (last_byte)
    );

    rxq_scan #(.DEPTH(DEPTH), .WATCH(WATCH)) u_scan (
        .tags_i (tags),
        .rd_ptr (rd_ptr),
        .cnt    (cnt),
        .hit_o  (window_hit)
    );

    always_comb begin
        have_data  = (cnt != '0);
        rd_data    = have_data ? bottom.data : last_byte;
        st_crc_err = have_data && bottom.crc;
        st_ovr     = have_data && bottom.ovr;
        attn       = window_hit;
        irq        = window_hit;
        dma_req    = (cnt >= CNT_W'(WATCH)) && !window_hit;
    end

endmodule

// File: rtl/rx_tag_fifo_chk.sv
module rx_tag_fifo_chk #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             rd_en,
    input logic [7:0]       rd_data,
    input logic             st_crc_err,
    input logic             st_ovr,
    input logic             attn,
    input logic             irq,
    input logic             dma_req,
    input logic [CNT_W-1:0] cnt
);

    // R6
    dma_blocked_by_tag_chk: assert property (@(posedge clk) disable iff (rst)
        dma_req |-> !irq);

    // R5
    bottom_tag_raises_attn_chk: assert property (@(posedge clk) disable iff (rst)
        (st_crc_err || st_ovr) |-> attn);

    // R8
    empty_read_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0 && rd_en && !wr_en) |=> ($stable(rd_data) && cnt == '0));

    // R3
    depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(DEPTH));

    // R7
    full_swap_keeps_full_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_W'(DEPTH) && wr_en && rd_en) |=> cnt == CNT_W'(DEPTH));

    // R9
    reset_empties_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cnt == '0 && !attn && !dma_req));

endmodule

bind rx_tag_fifo rx_tag_fifo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .st_crc_err (st_crc_err),
    .st_ovr     (st_ovr),
    .attn       (attn),
    .irq        (irq),
    .dma_req    (dma_req),
    .cnt        (cnt)
);

// File: tb/rx_tag_fifo_bench.sv
`timescale 1ns/1ps
module rx_tag_fifo_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_eof = 1'b0;
    logic       wr_crc_bad = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       st_crc_err, st_ovr, attn, irq, dma_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rx_tag_fifo u_rx_tag_fifo (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .wr_eof(wr_eof), .wr_crc_bad(wr_crc_bad), .rd_en(rd_en),
        .rd_data(rd_data), .st_crc_err(st_crc_err), .st_ovr(st_ovr),
        .attn(attn), .irq(irq), .dma_req(dma_req)
    );

    typedef struct packed {
        logic       wr;
        logic [7:0] d;
        logic       eof;
        logic       crc;
        logic       rd;
        logic [7:0] x_data;
        logic       x_crc;
        logic       x_ovr;
        logic       x_attn;
        logic       x_dma;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'hA1, 1'b0, 1'b0, 1'b0, 8'hA1, 1'b0, 1'b0, 1'b0, 1'b0},
        '{1'b1, 8'hA2, 1'b1, 1'b1, 1'b0, 8'hA1, 1'b0, 1'b0, 1'b1, 1'b0},
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'hA2, 1'b1, 1'b0, 1'b1, 1'b0},
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'hA2, 1'b0, 1'b0, 1'b0, 1'b0},
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'hA2, 1'b0, 1'b0, 1'b0, 1'b0},
        '{1'b1, 8'h77, 1'b1, 1'b0, 1'b0, 8'h77, 1'b0, 1'b0, 1'b1, 1'b0}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic expect_out(input string req, input logic [7:0] d,
                              input logic c, input logic o,
                              input logic a, input logic m);
        check(req, "rd_data", 32'(rd_data), 32'(d));
        check(req, "st_crc_err", 32'(st_crc_err), 32'(c));
        check(req, "st_ovr", 32'(st_ovr), 32'(o));
        check(req, "attn", 32'(attn), 32'(a));
        check(req, "irq", 32'(irq), 32'(a));
        check(req, "dma_req", 32'(dma_req), 32'(m));
    endtask

    task automatic step(input logic w, input logic [7:0] d, input logic e,
                        input logic c, input logic r);
        wr_en = w; wr_data = d; wr_eof = e; wr_crc_bad = c; rd_en = r;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wr_eof = 1'b0; wr_crc_bad = 1'b0; rd_en = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R9: reset state
        expect_out("R9", 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);

        // Table: R2 CRC tag on bottom byte, R4 flags for bottom only,
        // R8 empty read, R5 end-of-frame tag alone raises attn
        for (int i = 0; i < NV; i++) begin
            step(VECS[i].wr, VECS[i].d, VECS[i].eof, VECS[i].crc, VECS[i].rd);
            expect_out("R2/R4/R5/R8", VECS[i].x_data, VECS[i].x_crc,
                       VECS[i].x_ovr, VECS[i].x_attn, VECS[i].x_dma);
        end

        // R9: reset clears a pending tagged byte
        do_reset();
        expect_out("R9", 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);

        // R1, R6: fill with untagged bytes, DMA request at 8 entries
        for (int k = 1; k <= 16; k++) begin
            step(1'b1, 8'(8'h10 + k - 1), 1'b0, 1'b0, 1'b0);
            expect_out("R6", 8'h10, 1'b0, 1'b0, 1'b0, k >= 8);
        end

        // R3: overrun drops 0xEE, tags 0x1F beyond the window
        step(1'b1, 8'hEE, 1'b0, 1'b0, 1'b0);
        expect_out("R3", 8'h10, 1'b0, 1'b0, 1'b0, 1'b1);

        // R1, R3, R5: drain; tag enters the window after eight reads
        for (int j = 1; j <= 16; j++) begin
            step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
            if (j < 16)
                expect_out("R3", 8'(8'h10 + j), 1'b0, j == 15, j >= 8, j < 8);
            else
                expect_out("R3", 8'h1F, 1'b0, 1'b0, 1'b0, 1'b0);
        end

        // R8: empty read after drain proves 0xEE was dropped
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        expect_out("R8", 8'h1F, 1'b0, 1'b0, 1'b0, 1'b0);

        // R7: simultaneous read and write on a full queue
        for (int k = 0; k < 16; k++) begin
            step(1'b1, 8'(8'h30 + k), 1'b0, 1'b0, 1'b0);
        end
        step(1'b1, 8'h55, 1'b0, 1'b0, 1'b1);
        expect_out("R7", 8'h31, 1'b0, 1'b0, 1'b0, 1'b1);
        for (int j = 1; j <= 16; j++) begin
            step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
            if (j < 15)
                expect_out("R7", 8'(8'h31 + j), 1'b0, 1'b0, 1'b0, j <= 8);
            else
                expect_out("R7", 8'h55, 1'b0, 1'b0, 1'b0, 1'b0);
        end

        // R8: repeated empty read keeps the last byte
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        expect_out("R8", 8'h55, 1'b0, 1'b0, 1'b0, 1'b0);

        done = 1'b1;
        finish_run();
    end

endmodule